// File: doc/BRIEF.md
# Lock-Protected Pad Configuration Bank

This block holds the electrical pad settings for one small general-purpose I/O port. Each pin has a peripheral-routing enable, a digital receiver enable, weak pull-up and pull-down enables, a drive strength of 2, 4 or 8 mA, an open-drain enable and a slew-limit enable. Software programs these settings through a simple single-cycle register port. The bank's outputs are per-pin vectors that go straight to the pad ring and to the pin multiplexer.

The settings that can make a board unsafe are the peripheral routing, both pulls and the receiver enable. A write to any of them is filtered per pin by a commit mask. The commit mask can only be changed after software writes a 32-bit unlock key to the lock register. Any write to the commit mask, whether or not it takes effect, re-arms the lock.

The hardware keeps the drive-strength selection and the pull selection self-consistent. Exactly one drive strength is active per pin, and a pin never has both pulls enabled. Slew limiting reaches the pad only in 8 mA mode. Open drain reaches the pad only while the pin is an output.

Top module: `pad_cfg_bank`

## Requirements
- R1: After reset the bank is locked, the commit mask equals the COMMIT_RST parameter (all ones by default), every pin drives 2 mA, and routing, receiver, pull, open-drain and slew enables are all 0.
- R2: Writing 0x4C4F434B to the lock register (address 0) unlocks the bank. Writing any other value to it locks the bank. Reading it returns 0 when unlocked and 1 when locked.
- R3: A write to the commit register (address 1) updates the mask only while the bank is unlocked and is ignored while locked. Every commit write leaves the bank locked.
- R4: On a write to the routing register (address 2) or the receiver register (address 3), only pins whose commit bit is 1 take the written value. The other pins keep their old value.
- R5: On a write to the pull-up register (address 4) or the pull-down register (address 5), only pins whose commit bit is 1 are affected.
- R6: A committed pull-up bit written as 1 clears that pin's pull-down, and the reverse also holds. Pull-up and pull-down are never both 1 for a pin.
- R7: Writing 1 to a pin's bit in the 2 mA, 4 mA or 8 mA register (addresses 6, 7, 8) selects that strength and clears the pin's bit in the other two registers. Exactly one drive output is 1 per pin in every cycle.
- R8: Writing 0 to the bit of the currently active strength returns that pin to 2 mA. Writing 0 to the bit of an inactive strength leaves the pin unchanged.
- R9: The slew-limit output of a pin is 1 only when its slew bit (address 10) is set and the pin is in 8 mA mode.
- R10: The open-drain output of a pin is 1 only when its open-drain bit (address 9) is set and pin_dir marks the pin as an output.
- R11: Each register reads back its stored value in the low N bits of bus_rdata, with the upper bits 0. Unmapped addresses read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 4 | Register word address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_dir | input | N | Pin direction from the port core, 1 = output |
| pad_altf | output | N | Peripheral routing enable |
| pad_den | output | N | Digital receiver enable |
| pad_pu | output | N | Weak pull-up enable |
| pad_pd | output | N | Weak pull-down enable |
| pad_drv2 | output | N | 2 mA drive selected |
| pad_drv4 | output | N | 4 mA drive selected |
| pad_drv8 | output | N | 8 mA drive selected |
| pad_od | output | N | Effective open-drain enable |
| pad_slew | output | N | Effective slew-limit enable |

## Verification
The assertions assume that bus_wr, bus_addr and bus_wdata are known and stable around each rising edge, and that at most one register is written per cycle. The stimulus drives all of these on the falling edge.

The random phase picks addresses that include one unmapped slot. It offers the unlock key often enough to reach the unlocked state many times, so commit writes land in both lock states. The drive writes are biased toward clearing the active strength, which exercises the fallback to 2 mA. pin_dir changes freely, because the block only combines it with stored bits.

// File: rtl/pad_cfg_pkg.sv
package pad_cfg_pkg;
   localparam logic [31:0] UNLOCK_KEY = 32'h4C4F_434B;
   localparam int unsigned ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      RG_LOCK   = 4'd0,
      RG_COMMIT = 4'd1,
      RG_ALTF   = 4'd2,
      RG_DEN    = 4'd3,
      RG_PUP    = 4'd4,
      RG_PDN    = 4'd5,
      RG_DRV2   = 4'd6,
      RG_DRV4   = 4'd7,
      RG_DRV8   = 4'd8,
      RG_ODRN   = 4'd9,
      RG_SLEW   = 4'd10
   } reg_sel_e;

   typedef enum logic [1:0] {
      DRV_2MA = 2'd0,
      DRV_4MA = 2'd1,
      DRV_8MA = 2'd2
   } drv_e;
endpackage

// File: rtl/pad_lock_ctrl.sv
module pad_lock_ctrl #(
   parameter int unsigned N = 8,
   parameter logic [N-1:0] COMMIT_RST = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_lock,
   input  logic          wr_commit,
   input  logic [31:0]   wdata,
   output logic          locked,
   output logic [N-1:0]  commit
);
   import pad_cfg_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked <= 1'b1;
         commit <= COMMIT_RST;
      end else if (wr_lock) begin
         locked <= (wdata != UNLOCK_KEY);
      end else if (wr_commit) begin
         if (!locked) commit <= wdata[N-1:0];
         locked <= 1'b1;
      end
   end
endmodule

// File: rtl/pad_drive_sel.sv
module pad_drive_sel #(
   parameter int unsigned N = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_d2,
   input  logic          wr_d4,
   input  logic          wr_d8,
   input  logic [N-1:0]  wbits,
   output logic [N-1:0]  drv2,
   output logic [N-1:0]  drv4,
   output logic [N-1:0]  drv8
);
   import pad_cfg_pkg::*;

   for (genvar i = 0; i < N; i++) begin : g_pin
      drv_e sel_q, sel_d;

      always_comb begin
         sel_d = sel_q;
         if (wr_d2) begin
            if (wbits[i]) sel_d = DRV_2MA;
         end else if (wr_d4) begin
            if (wbits[i])              sel_d = DRV_4MA;
            else if (sel_q == DRV_4MA) sel_d = DRV_2MA;
         end else if (wr_d8) begin
            if (wbits[i])              sel_d = DRV_8MA;
            else if (sel_q == DRV_8MA) sel_d = DRV_2MA;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sel_q <= DRV_2MA;
         else        sel_q <= sel_d;
      end

      assign drv2[i] = (sel_q == DRV_2MA);
      assign drv4[i] = (sel_q == DRV_4MA);
      assign drv8[i] = (sel_q == DRV_8MA);
   end
endmodule

// File: rtl/pad_pull_sel.sv
module pad_pull_sel #(
   parameter int unsigned N = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_up,
   input  logic          wr_dn,
   input  logic [N-1:0]  wbits,
   input  logic [N-1:0]  commit,
   output logic [N-1:0]  pull_up,
   output logic [N-1:0]  pull_dn
);
   logic [N-1:0] set_bits;
   assign set_bits = wbits & commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pull_up <= '0;
         pull_dn <= '0;
      end else if (wr_up) begin
         pull_up <= (pull_up & ~commit) | set_bits;
         pull_dn <= pull_dn & ~set_bits;
      end else if (wr_dn) begin
         pull_dn <= (pull_dn & ~commit) | set_bits;
         pull_up <= pull_up & ~set_bits;
      end
   end
endmodule

// File: rtl/pad_cfg_bank.sv
module pad_cfg_bank #(
   parameter int unsigned N = 8,
   parameter logic [N-1:0] COMMIT_RST = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [3:0]    bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   input  logic [N-1:0]  pin_dir,
   output logic [N-1:0]  pad_altf,
   output logic [N-1:0]  pad_den,
   output logic [N-1:0]  pad_pu,
   output logic [N-1:0]  pad_pd,
   output logic [N-1:0]  pad_drv2,
   output logic [N-1:0]  pad_drv4,
   output logic [N-1:0]  pad_drv8,
   output logic [N-1:0]  pad_od,
   output logic [N-1:0]  pad_slew
);
   import pad_cfg_pkg::*;

   if (N < 1 || N > 32) begin : g_bad_width
      $error("pad_cfg_bank: N must lie in 1..32");
   end

   logic          locked_q;
   logic [N-1:0]  commit_q;
   logic [N-1:0]  altf_q, den_q, od_q, slew_q;
   logic [N-1:0]  wbits;
   logic          we_lock, we_commit, we_altf, we_den, we_pup, we_pdn;
   logic          we_d2, we_d4, we_d8, we_od, we_slew;

   assign wbits     = bus_wdata[N-1:0];
   assign we_lock   = bus_wr && (bus_addr == RG_LOCK);
   assign we_commit = bus_wr && (bus_addr == RG_COMMIT);
   assign we_altf   = bus_wr && (bus_addr == RG_ALTF);
   assign we_den    = bus_wr && (bus_addr == RG_DEN);
   assign we_pup    = bus_wr && (bus_addr == RG_PUP);
   assign we_pdn    = bus_wr && (bus_addr == RG_PDN);
   assign we_d2     = bus_wr && (bus_addr == RG_DRV2);
   assign we_d4     = bus_wr && (bus_addr == RG_DRV4);
   assign we_d8     = bus_wr && (bus_addr == RG_DRV8);
   assign we_od     = bus_wr && (bus_addr == RG_ODRN);
   assign we_slew   = bus_wr && (bus_addr == RG_SLEW);

   pad_lock_ctrl #(.N(N), .COMMIT_RST(COMMIT_RST)) u_lock (
      .clk(clk), .rst_n(rst_n), .wr_lock(we_lock), .wr_commit(we_commit),
      .wdata(bus_wdata), .locked(locked_q), .commit(commit_q)
   );

   pad_drive_sel #(.N(N)) u_drive (
      .clk(clk), .rst_n(rst_n), .wr_d2(we_d2), .wr_d4(we_d4), .wr_d8(we_d8),
      .wbits(wbits), .drv2(pad_drv2), .drv4(pad_drv4), .drv8(pad_drv8)
   );

   pad_pull_sel #(.N(N)) u_pull (
      .clk(clk), .rst_n(rst_n), .wr_up(we_pup), .wr_dn(we_pdn),
      .wbits(wbits), .commit(commit_q), .pull_up(pad_pu), .pull_dn(pad_pd)
   );

   // committed registers: masked merge per pin
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         altf_q <= '0;
         den_q  <= '0;
      end else begin
         if (we_altf) altf_q <= (altf_q & ~commit_q) | (wbits & commit_q);
         if (we_den)  den_q  <= (den_q  & ~commit_q) | (wbits & commit_q);
      end
   end

   // ungated registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         od_q   <= '0;
         slew_q <= '0;
      end else begin
         if (we_od)   od_q   <= wbits;
         if (we_slew) slew_q <= wbits;
      end
   end

   assign pad_altf = altf_q;
   assign pad_den  = den_q;
   assign pad_od   = od_q & pin_dir;
   assign pad_slew = slew_q & pad_drv8;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RG_LOCK:   bus_rdata[0]   = locked_q;
         RG_COMMIT: bus_rdata[N-1:0] = commit_q;
         RG_ALTF:   bus_rdata[N-1:0] = altf_q;
         RG_DEN:    bus_rdata[N-1:0] = den_q;
         RG_PUP:    bus_rdata[N-1:0] = pad_pu;
         RG_PDN:    bus_rdata[N-1:0] = pad_pd;
         RG_DRV2:   bus_rdata[N-1:0] = pad_drv2;
         RG_DRV4:   bus_rdata[N-1:0] = pad_drv4;
         RG_DRV8:   bus_rdata[N-1:0] = pad_drv8;
         RG_ODRN:   bus_rdata[N-1:0] = od_q;
         RG_SLEW:   bus_rdata[N-1:0] = slew_q;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pad_cfg_bank_chk.sv
module pad_cfg_bank_chk #(
   parameter int unsigned N = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_wr,
   input logic [3:0]    bus_addr,
   input logic [31:0]   bus_wdata,
   input logic          locked,
   input logic [N-1:0]  commit,
   input logic [N-1:0]  altf,
   input logic [N-1:0]  drv2,
   input logic [N-1:0]  drv4,
   input logic [N-1:0]  drv8,
   input logic [N-1:0]  pull_up,
   input logic [N-1:0]  pull_dn
);
   import pad_cfg_pkg::*;

   assert_key_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RG_LOCK && bus_wdata == UNLOCK_KEY) |=> !locked);

   assert_bad_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RG_LOCK && bus_wdata != UNLOCK_KEY) |=> locked);

   assert_commit_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RG_COMMIT && locked) |=> $stable(commit));

   assert_commit_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RG_COMMIT) |=> locked);

   assert_altf_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RG_ALTF) |=> (((altf ^ $past(altf)) & ~$past(commit)) == '0));

   assert_pull_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_up & pull_dn) == '0);

   assert_drive_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((drv2 & drv4) == '0) && ((drv2 & drv8) == '0) && ((drv4 & drv8) == '0)
      && ((drv2 | drv4 | drv8) == {N{1'b1}}));
endmodule

bind pad_cfg_bank pad_cfg_bank_chk #(.N(N)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .locked(locked_q), .commit(commit_q), .altf(pad_altf),
   .drv2(pad_drv2), .drv4(pad_drv4), .drv8(pad_drv8),
   .pull_up(pad_pu), .pull_dn(pad_pd)
);

// File: tb/pad_cfg_bank_tb.sv
`timescale 1ns/1ps
module pad_cfg_bank_tb;
   localparam logic [31:0] KEY = 32'h4C4F_434B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  pin_dir = '0;
   logic [7:0]  pad_altf, pad_den, pad_pu, pad_pd, pad_drv2, pad_drv4, pad_drv8, pad_od, pad_slew;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // bench model
   bit       m_locked;
   bit [7:0] m_commit, m_altf, m_den, m_pu, m_pd, m_od, m_sl;
   int       m_drv [8];

   always #5 clk = ~clk;

   pad_cfg_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_dir(pin_dir),
      .pad_altf(pad_altf), .pad_den(pad_den), .pad_pu(pad_pu), .pad_pd(pad_pd),
      .pad_drv2(pad_drv2), .pad_drv4(pad_drv4), .pad_drv8(pad_drv8),
      .pad_od(pad_od), .pad_slew(pad_slew)
   );

   function automatic bit [7:0] exp_drv(int k);
      bit [7:0] v = '0;
      for (int i = 0; i < 8; i++) v[i] = (m_drv[i] == k);
      return v;
   endfunction

   function automatic bit [31:0] exp_read(int a);
      case (a)
         0:  return {31'b0, m_locked};
         1:  return {24'b0, m_commit};
         2:  return {24'b0, m_altf};
         3:  return {24'b0, m_den};
         4:  return {24'b0, m_pu};
         5:  return {24'b0, m_pd};
         6:  return {24'b0, exp_drv(0)};
         7:  return {24'b0, exp_drv(1)};
         8:  return {24'b0, exp_drv(2)};
         9:  return {24'b0, m_od};
         10: return {24'b0, m_sl};
         default: return 32'b0;
      endcase
   endfunction

   task automatic model_reset();
      m_locked = 1'b1; m_commit = 8'hFF;
      m_altf = '0; m_den = '0; m_pu = '0; m_pd = '0; m_od = '0; m_sl = '0;
      for (int i = 0; i < 8; i++) m_drv[i] = 0;
   endtask

   task automatic model_write(int a, bit [31:0] d);
      bit [7:0] e;
      case (a)
         0: m_locked = (d != KEY);
         1: begin if (!m_locked) m_commit = d[7:0]; m_locked = 1'b1; end
         2: m_altf = (m_altf & ~m_commit) | (d[7:0] & m_commit);
         3: m_den  = (m_den  & ~m_commit) | (d[7:0] & m_commit);
         4: begin e = d[7:0] & m_commit; m_pu = (m_pu & ~m_commit) | e; m_pd = m_pd & ~e; end
         5: begin e = d[7:0] & m_commit; m_pd = (m_pd & ~m_commit) | e; m_pu = m_pu & ~e; end
         6, 7, 8: for (int i = 0; i < 8; i++) begin
            if (d[i]) m_drv[i] = a - 6;
            else if (m_drv[i] == a - 6) m_drv[i] = 0;
         end
         9:  m_od = d[7:0];
         10: m_sl = d[7:0];
         default: ;
      endcase
   endtask

   task automatic chk(string tag, string what, bit [31:0] act, bit [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic wr(int a, bit [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic rd(string tag, int a);
      bus_addr = 4'(a);
      #1;
      chk(tag, $sformatf("read addr %0d", a), bus_rdata, exp_read(a));
   endtask

   task automatic check_outputs(string tag);
      #1;
      chk(tag, "pad_altf", {24'b0, pad_altf}, {24'b0, m_altf});
      chk(tag, "pad_den",  {24'b0, pad_den},  {24'b0, m_den});
      chk(tag, "pad_pu",   {24'b0, pad_pu},   {24'b0, m_pu});
      chk(tag, "pad_pd",   {24'b0, pad_pd},   {24'b0, m_pd});
      chk(tag, "pad_drv2", {24'b0, pad_drv2}, {24'b0, exp_drv(0)});
      chk(tag, "pad_drv4", {24'b0, pad_drv4}, {24'b0, exp_drv(1)});
      chk(tag, "pad_drv8", {24'b0, pad_drv8}, {24'b0, exp_drv(2)});
      chk(tag, "pad_od",   {24'b0, pad_od},   {24'b0, m_od & pin_dir});
      chk(tag, "pad_slew", {24'b0, pad_slew}, {24'b0, m_sl & exp_drv(2)});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_outputs("R1");
      rd("R1", 0); rd("R1", 1);

      // R3 commit write while locked is ignored
      wr(1, 32'h00);
      rd("R3", 1);
      // R2 bad key keeps locked, good key unlocks
      wr(0, 32'h4C4F_434A); rd("R2", 0);
      wr(0, KEY);           rd("R2", 0);
      // R3 commit accepted while unlocked, then relocked
      wr(1, 32'h0F);        rd("R3", 1); rd("R3", 0);
      // R4 gating of routing and receiver
      wr(2, 32'hFF); wr(3, 32'hAA); check_outputs("R4");
      // R5 / R6 pull gating and exclusion
      wr(4, 32'hFF); check_outputs("R5");
      wr(5, 32'h03); check_outputs("R6");
      chk("R6", "pull-up after pull-down", {24'b0, pad_pu}, 32'h0C);
      // R7 drive selection
      wr(0, KEY); wr(1, 32'hFF);
      wr(8, 32'h81); check_outputs("R7");
      chk("R7", "8 mA set", {24'b0, pad_drv8}, 32'h81);
      wr(7, 32'h01); check_outputs("R7");
      // R8 fallback and no-effect clear
      wr(7, 32'h00);
      chk("R8", "fallback to 2 mA", {24'b0, pad_drv2}, 32'h7F);
      wr(6, 32'h00);
      chk("R8", "inactive clear", {24'b0, pad_drv8}, 32'h80);
      // R9 slew only at 8 mA
      wr(10, 32'hFF);
      chk("R9", "slew effective", {24'b0, pad_slew}, 32'h80);
      // R10 open drain follows direction
      pin_dir = 8'h0F; wr(9, 32'hFF);
      chk("R10", "open drain effective", {24'b0, pad_od}, 32'h0F);
      // R11 readback including unmapped slot
      wr(11, 32'hFFFF_FFFF);
      for (int a = 0; a < 12; a++) rd("R11", a);
      check_outputs("R11");

      // constrained random phase
      for (int n = 0; n < 400; n++) begin
         int a;
         bit [31:0] d;
         a = int'($urandom_range(0, 11));
         d = $urandom();
         if (a == 0 && $urandom_range(0, 2) != 0) d = KEY;
         if (a >= 6 && a <= 8 && $urandom_range(0, 1) == 1) d = d & 32'h0000_0055;
         pin_dir = 8'($urandom());
         wr(a, d);
         check_outputs("R11 random");
         rd("R11 random", int'($urandom_range(0, 11)));
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule